// File: doc/BRIEF.md
# Remote DMA Port Handshake Controller

This block runs single-item remote DMA between local buffer memory and a host processor that reaches the data through an external holding latch. For a remote read, the block fetches one item from local memory, loads it into the latch with an active-low port-write strobe, and then raises a port request. The host takes the item and pulses its read acknowledge. That pulse starts the next local read, which refills the latch. For a remote write, the block raises the request first. On the host's acknowledge it takes the host's item from the latch and issues a local write. A byte counter, set when the job starts, decides when the run ends.

The request pin has two uses, chosen by a long-address bit in the configuration write. In short-address mode the pin is a plain driven request line. In long-address mode the same pin becomes an upper-address strobe. It pulses at the start of every local memory cycle so that an external latch can capture address bits 31..16, which come from two configured start-address bytes. In that mode the pin is driven only while the bus is granted. Until the first configuration write the pin is not driven at all. The local memory cycle itself lies outside this block and is reached through a request/done handshake.

Top module: `rdma_port_hs`

## Requirements
- R1: After reset `reqPinOe` is 0, `busy` is 0 and `portWrN` is 1. `reqPinOe` stays 0 until the first cycle with `cfgWrEn` high.
- R2: In short-address mode (`cfgLongAddr`=0 at the last configuration write), `reqPinOe` is 1 and `reqPinOut` is 1 exactly while the block waits for the host's acknowledge.
- R3: A `go` pulse starts a job only when the block is idle, has been configured and `goCount` is nonzero. In every other case the pulse is ignored. `goWrite`=1 selects a remote write and 0 selects a remote read.
- R4: Remote read: the block holds `memRdReq` high until `memDone` and captures `memRdData` into `latchData`. It then drives `portWrN` low for exactly one cycle. `latchData` does not change on the cycle in which `portWrN` rises.
- R5: `hostAck` passes through a synchronizer and only its rising edge is used. Each low-to-high pulse, however long, causes exactly one local memory cycle.
- R6: Remote write: on each acknowledge the block captures `latchIn`. It then holds `memWrReq` high until `memDone`, with `memWrData` equal to the captured value.
- R7: The remaining byte count drops by XFER_BYTES (default 2) per item and saturates at zero, so a job moves ceil(`goCount`/XFER_BYTES) items. When it ends, `busy` falls and `done` is high for exactly one cycle.
- R8: `memAddr` starts at `goAddr` and rises by XFER_BYTES after each item.
- R9: In long-address mode `reqPinOe` equals `busAck`. `reqPinOut` is high for exactly one cycle at the start of each local memory cycle. `upperAddr` is {`cfgStartHi1`, `cfgStartHi0`}, with `cfgStartHi1` as bits 31..24.
- R10: `memRdReq` and `memWrReq` are never high together, and neither is high while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgLongAddr | input | 1 | Long-address (32-bit) mode select |
| cfgStartHi0 | input | 8 | Start address bits 23..16 |
| cfgStartHi1 | input | 8 | Start address bits 31..24 |
| go | input | 1 | Job start pulse |
| goWrite | input | 1 | 1 = remote write, 0 = remote read |
| goAddr | input | AW | Local start address |
| goCount | input | CW | Job length in bytes |
| hostAck | input | 1 | Host acknowledge (asynchronous) |
| busAck | input | 1 | Bus grant, gates the pin in long-address mode |
| memDone | input | 1 | Local memory cycle completion |
| memRdData | input | DW | Local memory read data |
| latchIn | input | DW | Host item from the external latch |
| memRdReq | output | 1 | Local read request |
| memWrReq | output | 1 | Local write request |
| memAddr | output | AW | Local memory address |
| memWrData | output | DW | Local write data |
| portWrN | output | 1 | Active-low strobe that loads the external latch |
| latchData | output | DW | Data presented to the external latch |
| reqPinOut | output | 1 | Request / upper-address strobe pin value |
| reqPinOe | output | 1 | Pin output enable |
| upperAddr | output | 16 | Address bits 31..16 |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |

## Verification
The hardest case to reach is an acknowledge held high well past the synchronizer, arriving while the block is already in its next memory cycle. That pulse must not count a second time. The host model keeps `hostAck` high for four cycles on every item, and the memory model counts local cycles so that a duplicate refill shows up. A stray `go` is sent in the middle of a read job, and a reconfiguration into long-address mode while the bus grant is toggled covers the second use of the pin.

// File: rtl/rdma_port_pkg.sv
package rdma_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEM_RD,
    ST_PORT_WR,
    ST_HOST_RD,
    ST_HOST_WR,
    ST_MEM_WR
  } hsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadJob;
    logic decCount;
    logic incAddr;
    logic captureRd;
    logic captureHost;
    logic adsPulse;
    logic reqActive;
  } hsCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic goOk;
    logic cntZero;
    logic cntLast;
    logic ackRise;
  } hsStat_t;

endpackage

// File: rtl/rdma_port_dp.sv
module rdma_port_dp
  import rdma_port_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int XFER_BYTES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  hsCtl_t        ctl,
  output hsStat_t       stat,
  input  logic          cfgWrEn,
  input  logic          cfgLongAddr,
  input  logic [7:0]    cfgStartHi0,
  input  logic [7:0]    cfgStartHi1,
  input  logic [AW-1:0] goAddr,
  input  logic [CW-1:0] goCount,
  input  logic          hostAck,
  input  logic          busAck,
  input  logic [DW-1:0] memRdData,
  input  logic [DW-1:0] latchIn,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic [DW-1:0] latchData,
  output logic [15:0]   upperAddr,
  output logic          reqPinOut,
  output logic          reqPinOe
);

  localparam logic [CW-1:0] XFER_C = CW'(XFER_BYTES);
  localparam logic [AW-1:0] STEP_A = AW'(XFER_BYTES);

  logic                   configured;
  logic                   longMode;
  logic [15:0]            hiReg;
  logic [CW-1:0]          remain;
  logic [AW-1:0]          addrReg;
  logic [DW-1:0]          latchReg;
  logic [DW-1:0]          wrDataReg;
  logic                   adsReg;
  logic [SYNC_STAGES-1:0] ackSync;
  logic                   ackSyncd;
  logic                   ackPrev;

  // configuration state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      configured <= 1'b0;
      longMode   <= 1'b0;
      hiReg      <= '0;
    end else if (cfgWrEn) begin
      configured <= 1'b1;
      longMode   <= cfgLongAddr;
      hiReg      <= {cfgStartHi1, cfgStartHi0};
    end
  end

  // acknowledge synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackSync <= '0;
        else       ackSync <= hostAck;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackSync <= '0;
        else       ackSync <= {ackSync[SYNC_STAGES-2:0], hostAck};
      end
    end
  endgenerate

  assign ackSyncd = ackSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackPrev <= 1'b0;
    else       ackPrev <= ackSyncd;
  end

  // byte counter with saturation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (ctl.loadJob) begin
      remain <= goCount;
    end else if (ctl.decCount) begin
      remain <= (remain > XFER_C) ? (remain - XFER_C) : '0;
    end
  end

  // local address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctl.loadJob) begin
      addrReg <= goAddr;
    end else if (ctl.incAddr) begin
      addrReg <= addrReg + STEP_A;
    end
  end

  // data holding registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg  <= '0;
      wrDataReg <= '0;
    end else begin
      if (ctl.captureRd)   latchReg  <= memRdData;
      if (ctl.captureHost) wrDataReg <= latchIn;
    end
  end

  // upper-address strobe, one cycle at each memory cycle start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) adsReg <= 1'b0;
    else       adsReg <= ctl.adsPulse & longMode;
  end

  // pin mode selection
  always_comb begin
    if (!configured) begin
      reqPinOe  = 1'b0;
      reqPinOut = 1'b0;
    end else if (longMode) begin
      reqPinOe  = busAck;
      reqPinOut = adsReg;
    end else begin
      reqPinOe  = 1'b1;
      reqPinOut = ctl.reqActive;
    end
  end

  assign stat.goOk    = configured & (goCount != '0);
  assign stat.cntZero = (remain == '0);
  assign stat.cntLast = (remain <= XFER_C);
  assign stat.ackRise = ackSyncd & ~ackPrev;

  assign memAddr   = addrReg;
  assign memWrData = wrDataReg;
  assign latchData = latchReg;
  assign upperAddr = hiReg;

endmodule

// File: rtl/rdma_port_ctrl.sv
module rdma_port_ctrl
  import rdma_port_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    go,
  input  logic    goWrite,
  input  logic    memDone,
  input  hsStat_t stat,
  output hsCtl_t  ctl,
  output logic    memRdReq,
  output logic    memWrReq,
  output logic    portWrN,
  output logic    busy,
  output logic    done
);

  hsState_t st;
  hsState_t nxt;
  logic     finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= nxt;
      done <= finish;
    end
  end

  always_comb begin
    nxt    = st;
    ctl    = '0;
    finish = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (go && stat.goOk) begin
          ctl.loadJob = 1'b1;
          if (goWrite) begin
            nxt = ST_HOST_WR;
          end else begin
            nxt          = ST_MEM_RD;
            ctl.adsPulse = 1'b1;
          end
        end
      end
      ST_MEM_RD: begin
        if (memDone) begin
          ctl.captureRd = 1'b1;
          nxt           = ST_PORT_WR;
        end
      end
      ST_PORT_WR: begin
        ctl.decCount = 1'b1;
        ctl.incAddr  = 1'b1;
        nxt          = ST_HOST_RD;
      end
      ST_HOST_RD: begin
        ctl.reqActive = 1'b1;
        if (stat.ackRise) begin
          if (stat.cntZero) begin
            nxt    = ST_IDLE;
            finish = 1'b1;
          end else begin
            nxt          = ST_MEM_RD;
            ctl.adsPulse = 1'b1;
          end
        end
      end
      ST_HOST_WR: begin
        ctl.reqActive = 1'b1;
        if (stat.ackRise) begin
          ctl.captureHost = 1'b1;
          ctl.adsPulse    = 1'b1;
          nxt             = ST_MEM_WR;
        end
      end
      ST_MEM_WR: begin
        if (memDone) begin
          ctl.decCount = 1'b1;
          ctl.incAddr  = 1'b1;
          if (stat.cntLast) begin
            nxt    = ST_IDLE;
            finish = 1'b1;
          end else begin
            nxt = ST_HOST_WR;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign memRdReq = (st == ST_MEM_RD);
  assign memWrReq = (st == ST_MEM_WR);
  assign portWrN  = (st != ST_PORT_WR);
  assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/rdma_port_hs.sv
module rdma_port_hs
  import rdma_port_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int XFER_BYTES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgLongAddr,
  input  logic [7:0]    cfgStartHi0,
  input  logic [7:0]    cfgStartHi1,
  input  logic          go,
  input  logic          goWrite,
  input  logic [AW-1:0] goAddr,
  input  logic [CW-1:0] goCount,
  input  logic          hostAck,
  input  logic          busAck,
  input  logic          memDone,
  input  logic [DW-1:0] memRdData,
  input  logic [DW-1:0] latchIn,
  output logic          memRdReq,
  output logic          memWrReq,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic          portWrN,
  output logic [DW-1:0] latchData,
  output logic          reqPinOut,
  output logic          reqPinOe,
  output logic [15:0]   upperAddr,
  output logic          busy,
  output logic          done
);

  hsCtl_t  ctl;
  hsStat_t stat;

  rdma_port_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .go       (go),
    .goWrite  (goWrite),
    .memDone  (memDone),
    .stat     (stat),
    .ctl      (ctl),
    .memRdReq (memRdReq),
    .memWrReq (memWrReq),
    .portWrN  (portWrN),
    .busy     (busy),
    .done     (done)
  );

  rdma_port_dp #(
    .AW          (AW),
    .DW          (DW),
    .CW          (CW),
    .XFER_BYTES  (XFER_BYTES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .stat        (stat),
    .cfgWrEn     (cfgWrEn),
    .cfgLongAddr (cfgLongAddr),
    .cfgStartHi0 (cfgStartHi0),
    .cfgStartHi1 (cfgStartHi1),
    .goAddr      (goAddr),
    .goCount     (goCount),
    .hostAck     (hostAck),
    .busAck      (busAck),
    .memRdData   (memRdData),
    .latchIn     (latchIn),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .latchData   (latchData),
    .upperAddr   (upperAddr),
    .reqPinOut   (reqPinOut),
    .reqPinOe    (reqPinOe)
  );

endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgWrEn,
  input logic          cfgLongAddr,
  input logic          busAck,
  input logic          reqPinOe,
  input logic          reqPinOut,
  input logic          portWrN,
  input logic [DW-1:0] latchData,
  input logic          memRdReq,
  input logic          memWrReq,
  input logic          busy,
  input logic          done
);

  logic cfgSeen;
  logic longSeen;
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSeen  <= 1'b0;
      longSeen <= 1'b0;
      primed   <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (cfgWrEn) begin
        cfgSeen  <= 1'b1;
        longSeen <= cfgLongAddr;
      end
    end
  end

  a_r1_hiz_until_cfg: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSeen |-> !reqPinOe);

  a_r2_short_pin_driven: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSeen && !longSeen) |-> reqPinOe);

  a_r4_portwr_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !portWrN |=> portWrN);

  a_r4_latch_stable_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $rose(portWrN)) |-> $stable(latchData));

  a_r9_long_oe_tracks_grant: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSeen && longSeen) |-> (reqPinOe == busAck));

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSeen && longSeen && reqPinOut) |=> !reqPinOut);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r10_req_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdReq && memWrReq));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdReq && !memWrReq));

endmodule

bind rdma_port_hs rdma_port_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWrEn     (cfgWrEn),
  .cfgLongAddr (cfgLongAddr),
  .busAck      (busAck),
  .reqPinOe    (reqPinOe),
  .reqPinOut   (reqPinOut),
  .portWrN     (portWrN),
  .latchData   (latchData),
  .memRdReq    (memRdReq),
  .memWrReq    (memWrReq),
  .busy        (busy),
  .done        (done)
);

// File: tb/tb_rdma_port_hs.sv
module tb_rdma_port_hs;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int XB = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0, cfgLongAddr = 1'b0;
  logic [7:0]    cfgStartHi0 = '0, cfgStartHi1 = '0;
  logic          go = 1'b0, goWrite = 1'b0;
  logic [AW-1:0] goAddr = '0;
  logic [CW-1:0] goCount = '0;
  logic          hostAck = 1'b0, busAck = 1'b0, memDone = 1'b0;
  logic [DW-1:0] memRdData = '0, latchIn = '0;
  logic          memRdReq, memWrReq, portWrN, reqPinOut, reqPinOe, busy, done;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData, latchData;
  logic [15:0]   upperAddr;

  always #5 clk = ~clk;

  rdma_port_hs dut (.*);

  int checks = 0, fails = 0;
  int rdCount = 0, doneCount = 0, adsCount = 0, pwRises = 0;
  bit longTb = 1'b0;
  logic prevPw = 1'b1;
  logic [DW-1:0] rdExpQ[$];
  logic [AW+DW-1:0] wrExpQ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle done, read data derived from address, writes scored
  initial begin
    forever begin
      @(negedge clk);
      if (memDone) begin
        memDone = 1'b0;
      end else if (rstN && (memRdReq || memWrReq)) begin
        if (memWrReq) begin
          if (wrExpQ.size() == 0) begin
            check(1'b0, "R6 unexpected local write", longint'(memAddr), 0);
          end else begin
            logic [AW+DW-1:0] e;
            e = wrExpQ.pop_front();
            check(memAddr == e[AW+DW-1:DW], "R8 write address", longint'(memAddr), longint'(e[AW+DW-1:DW]));
            check(memWrData == e[DW-1:0], "R6 write data", longint'(memWrData), longint'(e[DW-1:0]));
          end
        end else begin
          rdCount++;
          memRdData = memAddr ^ 16'h5A3C;
        end
        memDone = 1'b1;
      end
    end
  end

  // monitor: latch loads, strobe pulses, done pulses
  always @(negedge clk) begin
    if (rstN && prevPw === 1'b0 && portWrN === 1'b1) begin
      pwRises++;
      if (rdExpQ.size() == 0) begin
        check(1'b0, "R4 unexpected latch load", longint'(latchData), 0);
      end else begin
        logic [DW-1:0] e;
        e = rdExpQ.pop_front();
        check(latchData == e, "R4 R8 latch data", longint'(latchData), longint'(e));
      end
      if (!longTb) check(reqPinOut == 1'b1, "R2 request while waiting", longint'(reqPinOut), 1);
    end
    prevPw = portWrN;
    if (rstN && longTb && reqPinOe && reqPinOut) adsCount++;
    if (rstN && done) doneCount++;
  end

  task automatic pulseGo(input bit wr, input logic [AW-1:0] a, input logic [CW-1:0] c);
    goWrite = wr; goAddr = a; goCount = c; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic configure(input bit lng, input logic [7:0] h1, input logic [7:0] h0);
    cfgLongAddr = lng; cfgStartHi1 = h1; cfgStartHi0 = h0; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy !== 1'b0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runRead(input logic [AW-1:0] a, input logic [CW-1:0] c, input bit stray);
    int n = (int'(c) + XB - 1) / XB;
    int d0 = doneCount;
    int r0 = rdCount;
    int p0 = pwRises;
    for (int i = 0; i < n; i++) rdExpQ.push_back((a + AW'(i * XB)) ^ 16'h5A3C);
    pulseGo(1'b0, a, c);
    for (int i = 0; i < n; i++) begin
      while (pwRises < p0 + i + 1) @(negedge clk);
      hostAck = 1'b1;
      repeat (4) @(negedge clk);
      if (!longTb) check(reqPinOut == 1'b0, "R2 R5 request drops after ack", longint'(reqPinOut), 0);
      hostAck = 1'b0;
      repeat (2) @(negedge clk);
      if (stray && i == 0) pulseGo(1'b1, 16'h7770, 16'd2); // R3: ignored while busy
    end
    waitIdle();
    check(doneCount == d0 + 1, "R7 one done pulse", longint'(doneCount - d0), 1);
    check(rdCount == r0 + n, "R5 one refill per ack", longint'(rdCount - r0), longint'(n));
    check(rdExpQ.size() == 0, "R4 all items loaded", longint'(rdExpQ.size()), 0);
    check(!memRdReq && !memWrReq, "R10 idle quiet", longint'({memRdReq, memWrReq}), 0);
  endtask

  task automatic runWrite(input logic [AW-1:0] a, input logic [CW-1:0] c);
    int n = (int'(c) + XB - 1) / XB;
    int d0 = doneCount;
    for (int i = 0; i < n; i++)
      wrExpQ.push_back({a + AW'(i * XB), 16'hC100 + 16'(i * 7)});
    pulseGo(1'b1, a, c);
    for (int i = 0; i < n; i++) begin
      while (reqPinOut !== 1'b1) @(negedge clk);
      latchIn = 16'hC100 + 16'(i * 7);
      hostAck = 1'b1;
      repeat (4) @(negedge clk);
      hostAck = 1'b0;
      repeat (2) @(negedge clk);
    end
    waitIdle();
    check(doneCount == d0 + 1, "R7 write done pulse", longint'(doneCount - d0), 1);
    check(wrExpQ.size() == 0, "R6 all writes seen", longint'(wrExpQ.size()), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqPinOe == 1'b0, "R1 pin undriven after reset", longint'(reqPinOe), 0);
    check(busy == 1'b0, "R1 idle after reset", longint'(busy), 0);
    check(portWrN == 1'b1, "R1 strobe high after reset", longint'(portWrN), 1);

    pulseGo(1'b0, 16'h0040, 16'd4);
    @(negedge clk);
    check(busy == 1'b0, "R3 go ignored before config", longint'(busy), 0);
    check(reqPinOe == 1'b0, "R1 pin still undriven", longint'(reqPinOe), 0);

    configure(1'b0, 8'h12, 8'h34);
    check(reqPinOe == 1'b1, "R2 pin driven in short mode", longint'(reqPinOe), 1);
    check(reqPinOut == 1'b0, "R2 no request when idle", longint'(reqPinOut), 0);
    check(upperAddr == 16'h1234, "R9 upper address", longint'(upperAddr), 16'h1234);

    pulseGo(1'b0, 16'h0050, 16'd0);
    @(negedge clk);
    check(busy == 1'b0, "R3 zero count ignored", longint'(busy), 0);

    runRead(16'h0100, 16'd6, 1'b1);
    runRead(16'h0180, 16'd5, 1'b0);   // R7 saturating count, 3 items
    runWrite(16'h0200, 16'd4);
    runWrite(16'h0240, 16'd1);        // R7 single item from a short count

    busAck = 1'b0;
    configure(1'b1, 8'hAB, 8'hCD);
    longTb = 1'b1;
    check(reqPinOe == 1'b0, "R9 pin off without grant", longint'(reqPinOe), 0);
    check(upperAddr == 16'hABCD, "R9 upper address long", longint'(upperAddr), 16'hABCD);
    busAck = 1'b1;
    @(negedge clk);
    check(reqPinOe == 1'b1, "R9 pin on with grant", longint'(reqPinOe), 1);
    adsCount = 0;
    runRead(16'h0300, 16'd4, 1'b0);
    check(adsCount == 2, "R9 one strobe per memory cycle", longint'(adsCount), 2);

    summary();
    $finish;
  end

endmodule